// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block is a passive observer placed beside one load/store port, between a compute unit that issues memory operations and the memory-side buffer that serves them. It only reads the port and never drives it. The handshake it watches is not fire-and-forget. A busy level announces that an operation is in flight. The address held by the requester must stay put until busy drops. The memory side answers with single-cycle pulses: an address acceptance, an address exception, load-data valid, and, on the requester's side, store-data valid. Busy is released on a cycle that depends on how the operation ended.

Every cycle the monitor compares the port against nine protocol rules. Each rule owns one bit of a sticky error vector. A bit sets on the clock edge that ends the cycle in which its rule was broken. It stays set until a synchronous clear is applied. A single summary output is high whenever any bit is set. The address width and the length-field width are parameters.

Top module: `ldst_port_monitor`

## Requirements
- R1: A cycle with both the load request and the store request high sets error bit 0.
- R2: A request rising edge (either request goes high after a cycle with both low) in a cycle that follows a busy-high cycle sets error bit 1.
- R3: A request rising edge in a cycle where busy is low sets error bit 2.
- R4: Busy dropping (high in the previous cycle, low now) sets error bit 3, unless that cycle carries an address exception or load-data valid, or the previous cycle carried store-data valid.
- R5: Busy still high in a cycle carrying an address exception or load-data valid, or in the cycle after store-data valid, sets error bit 4.
- R6: Once address-valid has been seen high during a busy period, any later busy cycle in which address-valid is low, or the address or length value differs from the previous cycle, sets error bit 5. The cycle in which busy falls is exempt.
- R7: Address acceptance, address exception, load-data valid or store-data valid held high for two consecutive cycles sets error bit 6.
- R8: Error bit 7 is set by any of these: acceptance and exception in the same cycle; acceptance or store-data valid while busy is low; exception or load-data valid when busy was low in the previous cycle; load-data valid in an operation that started as a store; store-data valid in an operation that started as a load. The operation kind is the load request's value in the cycle where busy rises.
- R9: Store-data valid in a busy period with no address acceptance in an earlier cycle of that period sets error bit 8.
- R10: Error bits are sticky and become visible one cycle after the offending cycle. Clear empties the vector on the next edge, but a violation in the clear cycle is still recorded. Reset leaves the vector at zero, and the summary output equals the OR of all bits.
- R11: Well-formed load, store and address-exception operations leave the error vector at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the error vector |
| ld_req_i | input | 1 | Load request strobe |
| st_req_i | input | 1 | Store request strobe |
| len_i | input | LEN_W | Access length field |
| addr_vld_i | input | 1 | Address valid flag |
| addr_i | input | ADDR_W | Access address |
| busy_i | input | 1 | Port busy level |
| addr_ack_i | input | 1 | Address accepted pulse |
| addr_exc_i | input | 1 | Address exception pulse |
| ld_vld_i | input | 1 | Load data valid pulse |
| st_vld_i | input | 1 | Store data valid pulse |
| err_o | output | 1 | Any error bit set |
| err_code_o | output | 9 | Sticky error vector, one bit per rule |

## Verification
The bench builds the monitor with a 12-bit address and a 4-bit length field. With an address that narrow, the bench can flip the most significant address bit directly and confirm that the stability rule compares the whole bus, not only its low bits. The length width is kept at its default so that length changes use the same path as address changes. A behavioural model predicts the full error vector every cycle. On top of that, one scenario per rule targets its exact bit and checks that no neighbouring bit is set.

// File: rtl/ldsm_pkg.sv
package ldsm_pkg;

  localparam int NUM_RULES = 9;

  localparam int RB_BOTH_REQ  = 0;
  localparam int RB_REQ_BUSY  = 1;
  localparam int RB_NO_BUSY   = 2;
  localparam int RB_EARLY     = 3;
  localparam int RB_LATE      = 4;
  localparam int RB_ADDR_MOVE = 5;
  localparam int RB_WIDE      = 6;
  localparam int RB_STRAY     = 7;
  localparam int RB_ORDER     = 8;

  function automatic logic f_rise(input logic now, input logic prev);
    return now & ~prev;
  endfunction

  function automatic logic f_wide(input logic now, input logic prev);
    return now & prev;
  endfunction

  function automatic logic f_moved(input logic vld_now, input logic same_addr,
                                   input logic same_len);
    return ~vld_now | ~same_addr | ~same_len;
  endfunction

endpackage

// File: rtl/ldsm_history.sv
module ldsm_history #(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_req_i,
  input  logic              st_req_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic              addr_ack_i,
  input  logic              addr_exc_i,
  input  logic              ld_vld_i,
  input  logic              st_vld_i,
  output logic              busy_q,
  output logic              req_q,
  output logic              ack_q,
  output logic              exc_q,
  output logic              ldv_q,
  output logic              stv_q,
  output logic              av_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              op_ld_q,
  output logic              acked_q
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      ack_q   <= 1'b0;
      exc_q   <= 1'b0;
      ldv_q   <= 1'b0;
      stv_q   <= 1'b0;
      av_q    <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      op_ld_q <= 1'b0;
      acked_q <= 1'b0;
    end else begin
      busy_q <= busy_i;
      req_q  <= ld_req_i | st_req_i;
      ack_q  <= addr_ack_i;
      exc_q  <= addr_exc_i;
      ldv_q  <= ld_vld_i;
      stv_q  <= st_vld_i;
      av_q   <= addr_vld_i & busy_i;
      addr_q <= addr_i;
      len_q  <= len_i;
      if (busy_i && !busy_q) op_ld_q <= ld_req_i;
      if (!busy_i) acked_q <= 1'b0;
      else if (addr_ack_i) acked_q <= 1'b1;
    end
  end

endmodule

// File: rtl/ldsm_rules.sv
module ldsm_rules
  import ldsm_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 4
) (
  input  logic                 ld_req_i,
  input  logic                 st_req_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 addr_vld_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 busy_i,
  input  logic                 addr_ack_i,
  input  logic                 addr_exc_i,
  input  logic                 ld_vld_i,
  input  logic                 st_vld_i,
  input  logic                 busy_q,
  input  logic                 req_q,
  input  logic                 ack_q,
  input  logic                 exc_q,
  input  logic                 ldv_q,
  input  logic                 stv_q,
  input  logic                 av_q,
  input  logic [ADDR_W-1:0]    addr_q,
  input  logic [LEN_W-1:0]     len_q,
  input  logic                 op_ld_q,
  input  logic                 acked_q,
  output logic [NUM_RULES-1:0] hit_o
);

  logic req_start;
  logic done_evt;
  logic same_addr;
  logic same_len;
  logic stray;

  always_comb begin
    req_start = f_rise(ld_req_i | st_req_i, req_q);
    done_evt  = addr_exc_i | ld_vld_i | stv_q;
    same_addr = (addr_i == addr_q);
    same_len  = (len_i == len_q);
    stray     = (addr_ack_i & addr_exc_i)
              | (addr_ack_i & ~busy_i)
              | (st_vld_i & ~busy_i)
              | (addr_exc_i & ~busy_q)
              | (ld_vld_i & ~busy_q)
              | (ld_vld_i & busy_q & ~op_ld_q)
              | (st_vld_i & busy_i & op_ld_q);

    hit_o               = '0;
    hit_o[RB_BOTH_REQ]  = ld_req_i & st_req_i;
    hit_o[RB_REQ_BUSY]  = req_start & busy_q;
    hit_o[RB_NO_BUSY]   = req_start & ~busy_i;
    hit_o[RB_EARLY]     = busy_q & ~busy_i & ~done_evt;
    hit_o[RB_LATE]      = busy_i & done_evt;
    hit_o[RB_ADDR_MOVE] = busy_i & busy_q & av_q &
                          f_moved(addr_vld_i, same_addr, same_len);
    hit_o[RB_WIDE]      = f_wide(addr_ack_i, ack_q) | f_wide(addr_exc_i, exc_q)
                        | f_wide(ld_vld_i, ldv_q)   | f_wide(st_vld_i, stv_q);
    hit_o[RB_STRAY]     = stray;
    hit_o[RB_ORDER]     = st_vld_i & ~acked_q;
  end

endmodule

// File: rtl/ldsm_sticky.sv
module ldsm_sticky #(
  parameter int N = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] hit_i,
  output logic [N-1:0] err_q
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_q[g] <= 1'b0;
      else         err_q[g] <= (err_q[g] & ~clr_i) | hit_i[g];
    end
  end

endmodule

// File: rtl/ldst_port_monitor.sv
module ldst_port_monitor
  import ldsm_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 ld_req_i,
  input  logic                 st_req_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 addr_vld_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 busy_i,
  input  logic                 addr_ack_i,
  input  logic                 addr_exc_i,
  input  logic                 ld_vld_i,
  input  logic                 st_vld_i,
  output logic                 err_o,
  output logic [NUM_RULES-1:0] err_code_o
);

  logic              busy_q, req_q, ack_q, exc_q, ldv_q, stv_q, av_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              op_ld_q, acked_q;
  logic [NUM_RULES-1:0] hit_vec;

  ldsm_history #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ld_req_i(ld_req_i), .st_req_i(st_req_i), .len_i(len_i),
    .addr_vld_i(addr_vld_i), .addr_i(addr_i), .busy_i(busy_i),
    .addr_ack_i(addr_ack_i), .addr_exc_i(addr_exc_i),
    .ld_vld_i(ld_vld_i), .st_vld_i(st_vld_i),
    .busy_q(busy_q), .req_q(req_q), .ack_q(ack_q), .exc_q(exc_q),
    .ldv_q(ldv_q), .stv_q(stv_q), .av_q(av_q), .addr_q(addr_q),
    .len_q(len_q), .op_ld_q(op_ld_q), .acked_q(acked_q)
  );

  ldsm_rules #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_rules (
    .ld_req_i(ld_req_i), .st_req_i(st_req_i), .len_i(len_i),
    .addr_vld_i(addr_vld_i), .addr_i(addr_i), .busy_i(busy_i),
    .addr_ack_i(addr_ack_i), .addr_exc_i(addr_exc_i),
    .ld_vld_i(ld_vld_i), .st_vld_i(st_vld_i),
    .busy_q(busy_q), .req_q(req_q), .ack_q(ack_q), .exc_q(exc_q),
    .ldv_q(ldv_q), .stv_q(stv_q), .av_q(av_q), .addr_q(addr_q),
    .len_q(len_q), .op_ld_q(op_ld_q), .acked_q(acked_q),
    .hit_o(hit_vec)
  );

  ldsm_sticky #(.N(NUM_RULES)) u_sticky (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .hit_i(hit_vec), .err_q(err_code_o)
  );

  assign err_o = |err_code_o;

endmodule

// File: rtl/ldst_port_monitor_chk.sv
module ldst_port_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clr_i,
  input logic       ld_req_i,
  input logic       st_req_i,
  input logic       busy_i,
  input logic       addr_ack_i,
  input logic       addr_exc_i,
  input logic [8:0] hit_vec,
  input logic [8:0] err_code_o
);

  a_r1_both_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_req_i && st_req_i) |=> err_code_o[0]);

  a_r3_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ld_req_i || st_req_i) && !$past(ld_req_i || st_req_i) && !busy_i)
      |=> err_code_o[2]);

  a_r5_exc_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_exc_i && busy_i) |=> err_code_o[4]);

  a_r7_ack_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_ack_i && $past(addr_ack_i)) |=> err_code_o[6]);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((err_code_o & $past(err_code_o)) == $past(err_code_o)));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (err_code_o == $past(hit_vec)));

endmodule

bind ldst_port_monitor ldst_port_monitor_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
  .ld_req_i(ld_req_i), .st_req_i(st_req_i), .busy_i(busy_i),
  .addr_ack_i(addr_ack_i), .addr_exc_i(addr_exc_i),
  .hit_vec(hit_vec), .err_code_o(err_code_o)
);

// File: tb/ldst_port_monitor_tb_top.sv
module ldst_port_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, ld = 1'b0, st = 1'b0, av = 1'b0, bz = 1'b0;
  logic ack = 1'b0, exc = 1'b0, ldv = 1'b0, stv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] len = '0;
  logic err;
  logic [8:0] code;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_port_monitor #(.ADDR_W(AW), .LEN_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .ld_req_i(ld), .st_req_i(st), .len_i(len), .addr_vld_i(av),
    .addr_i(addr), .busy_i(bz), .addr_ack_i(ack), .addr_exc_i(exc),
    .ld_vld_i(ldv), .st_vld_i(stv), .err_o(err), .err_code_o(code)
  );

  // Behavioural reference: previous-cycle memory plus expected vector
  bit p_bz, p_req, p_ack, p_exc, p_ldv, p_stv, p_avseen, p_isld, p_gotack;
  int p_addr, p_len;
  bit [8:0] m_exp;

  always @(posedge clk) begin
    bit [8:0] h;
    bit rise;
    if (!rst_n) begin
      {p_bz, p_req, p_ack, p_exc, p_ldv, p_stv, p_avseen, p_isld, p_gotack} = '0;
      p_addr = 0; p_len = 0; m_exp = '0;
    end else begin
      h = '0;
      rise = (ld || st) && !p_req;
      if (ld && st) h[0] = 1;
      if (rise && p_bz) h[1] = 1;
      if (rise && !bz) h[2] = 1;
      if (p_bz && !bz && !(exc || ldv || p_stv)) h[3] = 1;
      if (bz && (exc || ldv || p_stv)) h[4] = 1;
      if (bz && p_bz && p_avseen && (!av || int'(addr) != p_addr || int'(len) != p_len)) h[5] = 1;
      if ((ack && p_ack) || (exc && p_exc) || (ldv && p_ldv) || (stv && p_stv)) h[6] = 1;
      if ((ack && exc) || (ack && !bz) || (stv && !bz) || (exc && !p_bz) || (ldv && !p_bz)
          || (ldv && p_bz && !p_isld) || (stv && bz && p_isld)) h[7] = 1;
      if (stv && !p_gotack) h[8] = 1;
      m_exp = (clr ? 9'h0 : m_exp) | h;
      if (bz && !p_bz) p_isld = ld;
      p_gotack = bz && (p_gotack || ack);
      p_bz = bz; p_req = ld || st; p_ack = ack; p_exc = exc;
      p_ldv = ldv; p_stv = stv; p_avseen = av && bz;
      p_addr = int'(addr); p_len = int'(len);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (code !== m_exp) begin
        bad++;
        $display("FAIL model R1..R11 per-cycle: actual=%h expected=%h", code, m_exp);
      end
    end
  end

  task automatic chk(input string req, input logic [8:0] exp);
    total++;
    if (code !== exp || err !== (|exp)) begin
      bad++;
      $display("FAIL %s: actual code=%h err=%b expected code=%h err=%b",
               req, code, err, exp, |exp);
    end
  endtask

  task automatic cyc(input logic l, s, v, b, a, e, dl, ds);
    ld = l; st = s; av = v; bz = b; ack = a; exc = e; ldv = dl; stv = ds;
    @(negedge clk);
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0,0); endtask

  task automatic clear();
    clr = 1'b1; idle(); clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    addr = 12'h123; len = 4'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk("R10 reset", 9'h000);

    // R11 legal load, store, exception
    cyc(1,0,1,1,0,0,0,0); cyc(1,0,1,1,1,0,0,0); cyc(1,0,1,0,0,0,1,0); idle();
    cyc(0,1,1,1,0,0,0,0); cyc(0,1,1,1,1,0,0,0); cyc(0,1,1,1,0,0,0,1);
    cyc(0,1,1,0,0,0,0,0); idle();
    cyc(1,0,1,1,0,0,0,0); cyc(1,0,1,0,0,1,0,0); idle();
    chk("R11 legal sequences", 9'h000);

    // R1 both requests
    cyc(1,1,1,1,0,0,0,0); cyc(1,0,1,0,0,1,0,0); idle();
    chk("R1 both requests", 9'h001);
    clear();

    // R2 new request while busy
    cyc(1,0,1,1,0,0,0,0); cyc(0,0,1,1,0,0,0,0); cyc(0,1,1,1,0,0,0,0);
    cyc(0,0,1,0,0,1,0,0); idle();
    chk("R2 request while busy", 9'h002);
    clear();

    // R3 request without busy
    cyc(1,0,0,0,0,0,0,0); idle();
    chk("R3 busy not raised", 9'h004);
    repeat (3) idle();
    chk("R10 sticky hold", 9'h004);
    clr = 1'b1; cyc(0,0,0,0,1,0,0,0); clr = 1'b0;
    chk("R10 clear with same-cycle hit", 9'h080);
    clear();
    chk("R10 clear empties", 9'h000);

    // R4 busy dropped without completion
    cyc(1,0,1,1,0,0,0,0); cyc(1,0,1,0,0,0,0,0); idle();
    chk("R4 early busy drop", 9'h008);
    clear();

    // R5 busy held through load data
    cyc(1,0,1,1,0,0,0,0); cyc(1,0,1,1,1,0,0,0); cyc(1,0,1,1,0,0,1,0);
    cyc(1,0,1,0,0,1,0,0); idle();
    chk("R5 busy late on load", 9'h010);
    clear();

    // R5 busy held after store data
    cyc(0,1,1,1,0,0,0,0); cyc(0,1,1,1,1,0,0,0); cyc(0,1,1,1,0,0,0,1);
    cyc(0,1,1,1,0,0,0,0); cyc(0,1,1,0,0,1,0,0); idle();
    chk("R5 busy late on store", 9'h010);
    clear();

    // R6 address MSB flip during busy
    cyc(1,0,1,1,0,0,0,0); addr = 12'h923; cyc(1,0,1,1,0,0,0,0);
    cyc(1,0,1,0,0,1,0,0); idle(); addr = 12'h123;
    chk("R6 address moved", 9'h020);
    clear();

    // R6 address-valid dropped during busy
    cyc(1,0,1,1,0,0,0,0); cyc(1,0,0,1,0,0,0,0); cyc(1,0,0,0,0,1,0,0); idle();
    chk("R6 address valid dropped", 9'h020);
    clear();

    // R6 length changed during busy
    cyc(1,0,1,1,0,0,0,0); len = 4'd4; cyc(1,0,1,1,0,0,0,0);
    cyc(1,0,1,0,0,1,0,0); idle(); len = 4'd2;
    chk("R6 length moved", 9'h020);
    clear();

    // R7 acceptance held two cycles
    cyc(1,0,1,1,0,0,0,0); cyc(1,0,1,1,1,0,0,0); cyc(1,0,1,1,1,0,0,0);
    cyc(1,0,1,0,0,0,1,0); idle();
    chk("R7 wide pulse", 9'h040);
    clear();

    // R8 acceptance when idle
    cyc(0,0,0,0,1,0,0,0); idle();
    chk("R8 stray acceptance", 9'h080);
    clear();

    // R8 acceptance with exception
    cyc(1,0,1,1,0,0,0,0); cyc(1,0,1,0,1,1,0,0); idle();
    chk("R8 accept and exception together", 9'h080);
    clear();

    // R8 load data inside a store operation
    cyc(0,1,1,1,0,0,0,0); cyc(0,1,1,1,1,0,0,0); cyc(0,1,1,0,0,0,1,0); idle();
    chk("R8 load data in store", 9'h080);
    clear();

    // R9 store data before acceptance
    cyc(0,1,1,1,0,0,0,0); cyc(0,1,1,1,0,0,0,1); cyc(0,1,1,0,0,0,0,0); idle();
    chk("R9 store before accept", 9'h100);
    clear();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule